// File: doc/BRIEF.md
# Segmented Memory Address Generator

This block forms the operand address for a memory reference in a 16-bit segmented processor. From an addressing-mode code it picks an optional base register (BX or BP), an optional index register (SI or DI) and an optional displacement. It adds them into a 16-bit effective address (EA). It then picks a segment register and forms 20-bit physical addresses for both bytes of a word operand.

The default segment is SS when the base is BP and DS otherwise. A segment override replaces the default segment. Register and immediate operand modes do not address memory: for these the block raises a no-memory flag and drives the address outputs to zero.

Each request is a one-cycle strobe with its operands. The results appear on registered outputs one cycle later, together with an output strobe. Instruction decoding and the bus cycle belong to neighbouring blocks.

Top module: `seg_addr_gen`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. The data outputs load only when `in_valid` is high and otherwise hold their values.
- R2: Mode codes: 2 is displacement only; 3, 4 and 5 are BX, SI and DI alone; 6, 7, 8 and 9 are BX, BP, SI and DI plus displacement; 10, 11, 12 and 13 are BX+SI, BX+DI, BP+SI and BP+DI plus displacement. `out_ea` is the sum of the selected terms.
- R3: When `disp_wide` is 0, only `disp[7:0]` is used, sign-extended to 16 bits. When it is 1, all of `disp` is used.
- R4: The EA sum wraps modulo 2^16.
- R5: With no override, modes 7, 12 and 13 select SS. All other memory modes, including mode 2, select DS. `out_seg` encodes ES=0, CS=1, SS=2 and DS=3.
- R6: When `ovr_en` is 1, the segment coded on `ovr_sel` (same encoding as R5) replaces the default segment in every memory mode.
- R7: `out_pa_lo` = (segment value × 16 + EA) mod 2^20.
- R8: `out_pa_hi` = (segment value × 16 + ((EA + 1) mod 2^16)) mod 2^20.
- R9: Modes 0 (register), 1 (immediate), 14 and 15 set `out_nomem`. In these modes `out_ea`, `out_seg`, `out_pa_lo` and `out_pa_hi` are zero. Memory modes clear `out_nomem`.
- R10: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| in_valid | input | 1 | Request strobe |
| mode | input | 4 | Addressing-mode code |
| disp_wide | input | 1 | 1: 16-bit displacement, 0: 8-bit |
| disp | input | 16 | Displacement |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| ovr_en | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment code |
| out_valid | output | 1 | Result strobe |
| out_nomem | output | 1 | Operand is not in memory |
| out_ea | output | 16 | Effective address |
| out_seg | output | 2 | Chosen segment code |
| out_pa_lo | output | 20 | Physical address of the low byte |
| out_pa_hi | output | 20 | Physical address of the high byte |

## Verification
The bench builds the block with its default 16-bit offsets and 4-bit segment shift, which matches the real address map. With these values the full cross of all 16 mode codes, five override choices and both displacement sizes can be swept over four register and segment sets. Those sets place the EA sum, the EA+1 step and the 20-bit sum on their wrap points. A negative 8-bit displacement exercises sign extension in every mode that uses a displacement.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  typedef enum logic [3:0] {
    AM_REG     = 4'd0,
    AM_IMM     = 4'd1,
    AM_DIRECT  = 4'd2,
    AM_IND_BX  = 4'd3,
    AM_IND_SI  = 4'd4,
    AM_IND_DI  = 4'd5,
    AM_BX_D    = 4'd6,
    AM_BP_D    = 4'd7,
    AM_SI_D    = 4'd8,
    AM_DI_D    = 4'd9,
    AM_BX_SI_D = 4'd10,
    AM_BX_DI_D = 4'd11,
    AM_BP_SI_D = 4'd12,
    AM_BP_DI_D = 4'd13,
    AM_RSV14   = 4'd14,
    AM_RSV15   = 4'd15
  } amode_e;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_e;

  // Term selection produced by the mode decoder
  typedef struct packed {
    logic no_mem;
    logic use_base;
    logic base_bp;
    logic use_index;
    logic index_di;
    logic use_disp;
  } acc_plan_t;

endpackage

// File: rtl/sa_mode_decode.sv
module sa_mode_decode
  import seg_addr_pkg::*;
(
  input  logic [3:0] mode_i,
  output acc_plan_t  plan_o
);

  always_comb begin
    plan_o = '0;
    case (amode_e'(mode_i))
      AM_DIRECT:  plan_o.use_disp = 1'b1;
      AM_IND_BX:  plan_o.use_base = 1'b1;
      AM_IND_SI:  plan_o.use_index = 1'b1;
      AM_IND_DI: begin
        plan_o.use_index = 1'b1;
        plan_o.index_di  = 1'b1;
      end
      AM_BX_D: begin
        plan_o.use_base = 1'b1;
        plan_o.use_disp = 1'b1;
      end
      AM_BP_D: begin
        plan_o.use_base = 1'b1;
        plan_o.base_bp  = 1'b1;
        plan_o.use_disp = 1'b1;
      end
      AM_SI_D: begin
        plan_o.use_index = 1'b1;
        plan_o.use_disp  = 1'b1;
      end
      AM_DI_D: begin
        plan_o.use_index = 1'b1;
        plan_o.index_di  = 1'b1;
        plan_o.use_disp  = 1'b1;
      end
      AM_BX_SI_D: begin
        plan_o.use_base  = 1'b1;
        plan_o.use_index = 1'b1;
        plan_o.use_disp  = 1'b1;
      end
      AM_BX_DI_D: begin
        plan_o.use_base  = 1'b1;
        plan_o.use_index = 1'b1;
        plan_o.index_di  = 1'b1;
        plan_o.use_disp  = 1'b1;
      end
      AM_BP_SI_D: begin
        plan_o.use_base  = 1'b1;
        plan_o.base_bp   = 1'b1;
        plan_o.use_index = 1'b1;
        plan_o.use_disp  = 1'b1;
      end
      AM_BP_DI_D: begin
        plan_o.use_base  = 1'b1;
        plan_o.base_bp   = 1'b1;
        plan_o.use_index = 1'b1;
        plan_o.index_di  = 1'b1;
        plan_o.use_disp  = 1'b1;
      end
      default: plan_o.no_mem = 1'b1;  // register, immediate, reserved
    endcase
  end

  // A memory plan always has at least one address term
  always_comb begin
    AST_PLAN_NONEMPTY: assert (plan_o.no_mem || plan_o.use_base || plan_o.use_index || plan_o.use_disp); // R2
  end

endmodule

// File: rtl/sa_ea_adder.sv
module sa_ea_adder
  import seg_addr_pkg::*;
#(
  parameter int OFS_W = 16,
  parameter int DSP_NARROW_W = 8
) (
  input  acc_plan_t          plan_i,
  input  logic [OFS_W-1:0]   bx_i,
  input  logic [OFS_W-1:0]   bp_i,
  input  logic [OFS_W-1:0]   si_i,
  input  logic [OFS_W-1:0]   di_i,
  input  logic [OFS_W-1:0]   disp_i,
  input  logic               disp_wide_i,
  output logic [OFS_W-1:0]   ea_o,
  output logic [OFS_W-1:0]   ea_next_o
);

  localparam int EXT_W = OFS_W - DSP_NARROW_W;

  logic [OFS_W-1:0] base_term;
  logic [OFS_W-1:0] index_term;
  logic [OFS_W-1:0] disp_term;
  logic [OFS_W-1:0] disp_ext;

  always_comb begin
    disp_ext   = disp_wide_i ? disp_i
                             : {{EXT_W{disp_i[DSP_NARROW_W-1]}}, disp_i[DSP_NARROW_W-1:0]};
    base_term  = !plan_i.use_base  ? '0 : (plan_i.base_bp  ? bp_i : bx_i);
    index_term = !plan_i.use_index ? '0 : (plan_i.index_di ? di_i : si_i);
    disp_term  = plan_i.use_disp ? disp_ext : '0;
    ea_o       = base_term + index_term + disp_term;  // wraps in OFS_W bits
    ea_next_o  = ea_o + OFS_W'(1);
  end

endmodule

// File: rtl/sa_phys_calc.sv
module sa_phys_calc
  import seg_addr_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PA_W      = OFS_W + SEG_SHIFT
) (
  input  logic [OFS_W-1:0] es_i,
  input  logic [OFS_W-1:0] cs_i,
  input  logic [OFS_W-1:0] ss_i,
  input  logic [OFS_W-1:0] ds_i,
  input  logic             base_bp_i,
  input  logic             ovr_en_i,
  input  logic [1:0]       ovr_sel_i,
  input  logic [OFS_W-1:0] ea_i,
  input  logic [OFS_W-1:0] ea_next_i,
  output seg_e             seg_o,
  output logic [PA_W-1:0]  pa_lo_o,
  output logic [PA_W-1:0]  pa_hi_o
);

  logic [OFS_W-1:0] seg_val;
  logic [PA_W-1:0]  seg_base;

  always_comb begin
    if (ovr_en_i)       seg_o = seg_e'(ovr_sel_i);
    else if (base_bp_i) seg_o = SEG_SS;
    else                seg_o = SEG_DS;

    case (seg_o)
      SEG_ES:  seg_val = es_i;
      SEG_CS:  seg_val = cs_i;
      SEG_SS:  seg_val = ss_i;
      default: seg_val = ds_i;
    endcase

    seg_base = {seg_val, {SEG_SHIFT{1'b0}}};
    pa_lo_o  = seg_base + {{SEG_SHIFT{1'b0}}, ea_i};
    pa_hi_o  = seg_base + {{SEG_SHIFT{1'b0}}, ea_next_i};
  end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PA_W     = OFS_W + SEG_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [3:0]       mode,
  input  logic             disp_wide,
  input  logic [OFS_W-1:0] disp,
  input  logic [OFS_W-1:0] reg_bx,
  input  logic [OFS_W-1:0] reg_bp,
  input  logic [OFS_W-1:0] reg_si,
  input  logic [OFS_W-1:0] reg_di,
  input  logic [OFS_W-1:0] seg_es,
  input  logic [OFS_W-1:0] seg_cs,
  input  logic [OFS_W-1:0] seg_ss,
  input  logic [OFS_W-1:0] seg_ds,
  input  logic             ovr_en,
  input  logic [1:0]       ovr_sel,
  output logic             out_valid,
  output logic             out_nomem,
  output logic [OFS_W-1:0] out_ea,
  output logic [1:0]       out_seg,
  output logic [PA_W-1:0]  out_pa_lo,
  output logic [PA_W-1:0]  out_pa_hi
);

  acc_plan_t        plan;
  logic [OFS_W-1:0] ea_sum;
  logic [OFS_W-1:0] ea_sum_next;
  seg_e             seg_pick;
  logic [PA_W-1:0]  pa_lo_c;
  logic [PA_W-1:0]  pa_hi_c;

  sa_mode_decode u_dec (
    .mode_i (mode),
    .plan_o (plan)
  );

  sa_ea_adder #(.OFS_W(OFS_W)) u_ea (
    .plan_i      (plan),
    .bx_i        (reg_bx),
    .bp_i        (reg_bp),
    .si_i        (reg_si),
    .di_i        (reg_di),
    .disp_i      (disp),
    .disp_wide_i (disp_wide),
    .ea_o        (ea_sum),
    .ea_next_o   (ea_sum_next)
  );

  sa_phys_calc #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_pa (
    .es_i      (seg_es),
    .cs_i      (seg_cs),
    .ss_i      (seg_ss),
    .ds_i      (seg_ds),
    .base_bp_i (plan.base_bp),
    .ovr_en_i  (ovr_en),
    .ovr_sel_i (ovr_sel),
    .ea_i      (ea_sum),
    .ea_next_i (ea_sum_next),
    .seg_o     (seg_pick),
    .pa_lo_o   (pa_lo_c),
    .pa_hi_o   (pa_hi_c)
  );

  // Next-state logic
  logic             nomem_d;
  logic [OFS_W-1:0] ea_d;
  logic [1:0]       seg_d;
  logic [PA_W-1:0]  pa_lo_d;
  logic [PA_W-1:0]  pa_hi_d;

  always_comb begin
    nomem_d = plan.no_mem;
    if (plan.no_mem) begin
      ea_d    = '0;
      seg_d   = '0;
      pa_lo_d = '0;
      pa_hi_d = '0;
    end else begin
      ea_d    = ea_sum;
      seg_d   = seg_pick;
      pa_lo_d = pa_lo_c;
      pa_hi_d = pa_hi_c;
    end
  end

  // Registers: strobe every cycle, data under clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_nomem <= 1'b0;
      out_ea    <= '0;
      out_seg   <= '0;
      out_pa_lo <= '0;
      out_pa_hi <= '0;
    end else if (in_valid) begin
      out_nomem <= nomem_d;
      out_ea    <= ea_d;
      out_seg   <= seg_d;
      out_pa_lo <= pa_lo_d;
      out_pa_hi <= pa_hi_d;
    end
  end

  // Checks
  AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R1
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R1
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_ea) && $stable(out_pa_lo) && $stable(out_seg)); // R1
  AST_BP_DEFAULTS_SS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !ovr_en && (mode == 4'd7 || mode == 4'd12 || mode == 4'd13) |=> out_seg == 2'd2); // R5
  AST_OVERRIDE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ovr_en |=> out_nomem || out_seg == $past(ovr_sel)); // R6
  AST_NOMEM_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_nomem |-> out_ea == '0 && out_pa_lo == '0 && out_pa_hi == '0); // R9
  AST_HI_BYTE_ADJ: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_nomem && out_ea != {OFS_W{1'b1}} |-> out_pa_hi == PA_W'(out_pa_lo + PA_W'(1))); // R8
  AST_HI_BYTE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_nomem && out_ea == {OFS_W{1'b1}} |-> out_pa_hi == PA_W'(out_pa_lo - PA_W'({OFS_W{1'b1}}))); // R8

endmodule

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  mode;
  logic        disp_wide;
  logic [15:0] disp, reg_bx, reg_bp, reg_si, reg_di;
  logic [15:0] seg_es, seg_cs, seg_ss, seg_ds;
  logic        ovr_en;
  logic [1:0]  ovr_sel;
  logic        out_valid, out_nomem;
  logic [15:0] out_ea;
  logic [1:0]  out_seg;
  logic [19:0] out_pa_lo, out_pa_hi;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .disp_wide(disp_wide), .disp(disp), .reg_bx(reg_bx), .reg_bp(reg_bp),
    .reg_si(reg_si), .reg_di(reg_di), .seg_es(seg_es), .seg_cs(seg_cs),
    .seg_ss(seg_ss), .seg_ds(seg_ds), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
    .out_valid(out_valid), .out_nomem(out_nomem), .out_ea(out_ea),
    .out_seg(out_seg), .out_pa_lo(out_pa_lo), .out_pa_hi(out_pa_hi)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s mode=%0d ovr=%0d/%0d wide=%0d: got %h expected %h",
               tag, what, mode, ovr_en, ovr_sel, disp_wide, got, exp);
    end
  endtask

  // Expected values of the request currently on the inputs
  logic        e_nomem;
  logic [15:0] e_ea;
  logic [1:0]  e_seg;
  logic [19:0] e_lo, e_hi;

  task automatic compute_expect();
    logic [15:0] b, x, d, sv;
    logic bp_base;
    b = 16'h0; x = 16'h0; d = 16'h0; bp_base = 1'b0; e_nomem = 1'b0;
    // R3: narrow displacement is sign-extended
    d = disp_wide ? disp : {{8{disp[7]}}, disp[7:0]};
    case (mode)
      4'd2:  ;
      4'd3:  begin b = reg_bx; d = 16'h0; end
      4'd4:  begin x = reg_si; d = 16'h0; end
      4'd5:  begin x = reg_di; d = 16'h0; end
      4'd6:  b = reg_bx;
      4'd7:  begin b = reg_bp; bp_base = 1'b1; end
      4'd8:  x = reg_si;
      4'd9:  x = reg_di;
      4'd10: begin b = reg_bx; x = reg_si; end
      4'd11: begin b = reg_bx; x = reg_di; end
      4'd12: begin b = reg_bp; x = reg_si; bp_base = 1'b1; end
      4'd13: begin b = reg_bp; x = reg_di; bp_base = 1'b1; end
      default: e_nomem = 1'b1;
    endcase
    if (e_nomem) begin
      e_ea = 16'h0; e_seg = 2'd0; e_lo = 20'h0; e_hi = 20'h0;
    end else begin
      e_ea  = 16'((32'(b) + 32'(x) + 32'(d)) % 32'h10000);   // R4
      e_seg = ovr_en ? ovr_sel : (bp_base ? 2'd2 : 2'd3);
      case (e_seg)
        2'd0: sv = seg_es;
        2'd1: sv = seg_cs;
        2'd2: sv = seg_ss;
        default: sv = seg_ds;
      endcase
      e_lo = 20'((32'(sv) * 16 + 32'(e_ea)) % 32'h100000);
      e_hi = 20'((32'(sv) * 16 + ((32'(e_ea) + 1) % 32'h10000)) % 32'h100000);
    end
  endtask

  task automatic load_set(input int s);
    case (s)
      0: begin  // ordinary values, negative 8-bit displacement (R3)
        reg_bx = 16'h1234; reg_bp = 16'h4000; reg_si = 16'h0010; reg_di = 16'h0F00;
        disp = 16'h0085;
        seg_es = 16'h1000; seg_cs = 16'h2000; seg_ss = 16'h3000; seg_ds = 16'h4000;
      end
      1: begin  // EA and PA wrap (R4, R7)
        reg_bx = 16'hFFFF; reg_bp = 16'hFFF0; reg_si = 16'h0002; reg_di = 16'h8000;
        disp = 16'h7F7F;
        seg_es = 16'hFFFF; seg_cs = 16'h0001; seg_ss = 16'hF000; seg_ds = 16'hFFFF;
      end
      2: begin  // EA lands on FFFF: high byte wraps to segment start (R8)
        reg_bx = 16'h0000; reg_bp = 16'h0000; reg_si = 16'h0000; reg_di = 16'h0000;
        disp = 16'hFFFF;
        seg_es = 16'hABCD; seg_cs = 16'h0F0F; seg_ss = 16'h8001; seg_ds = 16'hFFF0;
      end
      default: begin
        reg_bx = 16'h8001; reg_bp = 16'h7FFF; reg_si = 16'h7FFF; reg_di = 16'h0001;
        disp = 16'h1280;
        seg_es = 16'h0123; seg_cs = 16'h4567; seg_ss = 16'h89AB; seg_ds = 16'hCDEF;
      end
    endcase
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; mode = 4'd0; disp_wide = 1'b0; ovr_en = 1'b0; ovr_sel = 2'd0;
    load_set(0);
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "valid",  32'(out_valid), 32'd0);
    chk("R10", "nomem",  32'(out_nomem), 32'd0);
    chk("R10", "ea",     32'(out_ea),    32'd0);
    chk("R10", "pa_lo",  32'(out_pa_lo), 32'd0);
    chk("R10", "pa_hi",  32'(out_pa_hi), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 16; m++) begin
        for (int ov = 0; ov < 5; ov++) begin
          for (int w = 0; w < 2; w++) begin
            load_set(s);
            mode = 4'(m); disp_wide = w[0];
            ovr_en = (ov < 4); ovr_sel = 2'(ov);
            in_valid = 1'b1;
            compute_expect();
            @(negedge clk);
            chk("R1", "valid", 32'(out_valid), 32'd1);
            chk("R9", "nomem", 32'(out_nomem), 32'(e_nomem));
            chk(w ? "R2" : "R3", "ea", 32'(out_ea), 32'(e_ea));
            chk(ov < 4 ? "R6" : "R5", "seg", 32'(out_seg), 32'(e_seg));
            chk("R7", "pa_lo", 32'(out_pa_lo), 32'(e_lo));
            chk("R8", "pa_hi", 32'(out_pa_hi), 32'(e_hi));
          end
        end
      end
    end

    // R1: idle cycle with changed inputs leaves outputs untouched
    mode = 4'd10; ovr_en = 1'b0; load_set(3); disp_wide = 1'b1; in_valid = 1'b1;
    compute_expect();
    @(negedge clk);
    in_valid = 1'b0; load_set(1); mode = 4'd7;
    @(negedge clk);
    chk("R1", "idle valid", 32'(out_valid), 32'd0);
    chk("R1", "held ea",    32'(out_ea),    32'(e_ea));
    chk("R1", "held pa_lo", 32'(out_pa_lo), 32'(e_lo));

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule